// File: doc/BRIEF.md
# Posted Interrupt Notification Processor

This block handles the physical interrupt that a virtualized core receives from its local interrupt controller, and decides whether that interrupt delivers posted virtual interrupts. When an acknowledged physical vector arrives, the block compares it with a programmable notification vector. A vector that does not match leaves the guest as an external-interrupt VM exit, and the vector is reported alongside it. A matching vector starts a fixed four-step sequence on a posted-interrupt descriptor held in local registers. The sequence drops the outstanding-notification flag, dismisses the notification with a zero end-of-interrupt write, and moves the pending request bitmap into the virtual request register in one atomic step. It then raises the requesting-vector index where needed and strobes a request to evaluate pending virtual interrupts.

Interrupt sources post requests through a one-vector-per-transfer port. Each transfer sets one bitmap bit and the notification flag. The port is held off with its ready signal only during the merge cycle, so a request raised at any time is kept. Any vector other than the notification vector is treated as an ordinary external interrupt, and this includes a separate wakeup vector. Evaluation of the virtual interrupts and any memory bus traffic are handled elsewhere.

Top module: `pin_notify_unit`

## Requirements
- R1: An acknowledge (`ack_valid`) is taken only when `ack_ready` is high. `busy` is high from the cycle after an accepted acknowledge through the cycle of `exit_valid` or `eval_strobe`, and `ack_ready` is low whenever `busy` is high.
- R2: When the accepted vector differs from `cfg_notify_vec`, `exit_valid` is high for exactly the one cycle after acceptance, and `exit_vector` equals the vector. The descriptor stays unchanged, and neither `eoi_wr` nor `eval_strobe` is raised.
- R3: When the accepted vector equals `cfg_notify_vec`, `desc_on` is low in the second cycle after acceptance, and `desc_pir` still holds its value from before acceptance.
- R4: In that second cycle after acceptance, `eoi_wr` is high for one cycle and `eoi_data` is all zero.
- R5: In the third cycle after acceptance, `post_ready` is low. At the end of that cycle, `virr` becomes `virr | desc_pir` and `desc_pir` becomes zero in the same clock edge. Bits of `virr` are never cleared.
- R6: After the merge, `rvi` is the larger of its old value and the index of the highest set bit of the merged bitmap, where bit i stands for vector i. An all-zero bitmap leaves `rvi` unchanged.
- R7: `eval_strobe` is high for exactly the fourth cycle after acceptance, which is the last cycle of the sequence. The cycle before it is always the merge cycle.
- R8: A clock edge with `post_valid` and `post_ready` both high sets `desc_pir[post_bit]` and `desc_on`. A request held during the merge cycle is taken at the next edge and is not lost.
- R9: After reset, `desc_on`, `desc_pir`, `virr` and `rvi` are zero, `busy` is low, and `ack_ready` and `post_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_notify_vec | input | VEC_W | Programmed notification vector |
| ack_valid | input | 1 | Acknowledged physical interrupt present |
| ack_vector | input | VEC_W | Physical vector from the interrupt controller |
| ack_ready | output | 1 | Block can take an acknowledge |
| busy | output | 1 | A sequence or exit is in progress |
| exit_valid | output | 1 | External-interrupt VM exit request |
| exit_vector | output | VEC_W | Vector reported with the exit |
| eoi_wr | output | 1 | End-of-interrupt write strobe |
| eoi_data | output | VEC_W | End-of-interrupt write data (zero) |
| eval_strobe | output | 1 | Evaluate pending virtual interrupts |
| post_valid | input | 1 | Posting request |
| post_bit | input | VEC_W | Vector being posted |
| post_ready | output | 1 | Posting port can take a request |
| desc_on | output | 1 | Outstanding-notification flag |
| desc_pir | output | 2**VEC_W | Pending request bitmap |
| virr | output | 2**VEC_W | Virtual interrupt request register |
| rvi | output | VEC_W | Requesting virtual interrupt index |

## Verification
The checker evaluates the invariants on every cycle. These are: acknowledges are refused while busy, exits never coincide with the end-of-interrupt write or the evaluate strobe, the end-of-interrupt data is zero, the bitmap is empty right after the merge, the virtual request bits and the index never decrease, the strobe always follows a merge, and the posting port stalls only inside a sequence. Only the bench scenarios can show that the merged contents are correct. The same holds for the exact index value when every single-bit position is posted from reset, for the rule that an empty bitmap leaves the index alone, for every non-matching vector producing an exit with the descriptor left untouched, and for a request stalled in the merge cycle arriving intact afterwards.

// File: rtl/pin_pkg.sv
package pin_pkg;
    localparam int unsigned VEC_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXIT,
        ST_CLR,
        ST_EOI,
        ST_MERGE,
        ST_EVAL
    } pin_state_e;

    typedef struct packed {
        pin_state_e       state;
        logic [VEC_W-1:0] vec;
        logic             on;
        logic [VEC_W-1:0] rvi;
    } pin_ctl_t;
endpackage

// File: rtl/pin_prio_enc.sv
module pin_prio_enc #(
    parameter int unsigned W  = 256,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pin_onehot_dec.sv
module pin_onehot_dec #(
    parameter int unsigned IW = 8,
    parameter int unsigned W  = 1 << IW
) (
    input  logic          en,
    input  logic [IW-1:0] sel,
    output logic [W-1:0]  mask
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign mask[g] = en && (sel == IW'(g));
    end
endmodule

// File: rtl/pin_notify_unit.sv
module pin_notify_unit #(
    parameter int unsigned VEC_W = pin_pkg::VEC_W,
    localparam int unsigned NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] cfg_notify_vec,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vector,
    output logic             ack_ready,
    output logic             busy,
    output logic             exit_valid,
    output logic [VEC_W-1:0] exit_vector,
    output logic             eoi_wr,
    output logic [VEC_W-1:0] eoi_data,
    output logic             eval_strobe,
    input  logic             post_valid,
    input  logic [VEC_W-1:0] post_bit,
    output logic             post_ready,
    output logic             desc_on,
    output logic [NVEC-1:0]  desc_pir,
    output logic [NVEC-1:0]  virr,
    output logic [VEC_W-1:0] rvi
);
    import pin_pkg::*;

    typedef struct packed {
        pin_state_e       state;
        logic [VEC_W-1:0] vec;
        logic             on;
        logic [VEC_W-1:0] rvi;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic [NVEC-1:0] pir_d, pir_q;
    logic [NVEC-1:0] virr_d, virr_q;

    logic [NVEC-1:0]  post_mask;
    logic [VEC_W-1:0] top_idx;
    logic             top_valid;
    logic             post_fire;

    assign post_ready = (ctl_q.state != ST_MERGE);
    assign post_fire  = post_valid && post_ready;

    pin_onehot_dec #(.IW(VEC_W), .W(NVEC)) u_dec (
        .en   (post_fire),
        .sel  (post_bit),
        .mask (post_mask)
    );

    pin_prio_enc #(.W(NVEC), .IW(VEC_W)) u_enc (
        .vec   (pir_q),
        .idx   (top_idx),
        .valid (top_valid)
    );

    always_comb begin
        ctl_d  = ctl_q;
        pir_d  = pir_q;
        virr_d = virr_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ack_valid) begin
                    ctl_d.vec   = ack_vector;
                    ctl_d.state = (ack_vector == cfg_notify_vec) ? ST_CLR : ST_EXIT;
                end
            end
            ST_EXIT: ctl_d.state = ST_IDLE;
            ST_CLR: begin
                ctl_d.on    = 1'b0;
                ctl_d.state = ST_EOI;
            end
            ST_EOI: ctl_d.state = ST_MERGE;
            ST_MERGE: begin
                virr_d = virr_q | pir_q;
                pir_d  = '0;
                if (top_valid && (top_idx > ctl_q.rvi)) begin
                    ctl_d.rvi = top_idx;
                end
                ctl_d.state = ST_EVAL;
            end
            ST_EVAL: ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
        if (post_fire) begin
            pir_d    = pir_d | post_mask;
            ctl_d.on = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '{state: ST_IDLE, vec: '0, on: 1'b0, rvi: '0};
            pir_q  <= '0;
            virr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            pir_q  <= pir_d;
            virr_q <= virr_d;
        end
    end

    assign ack_ready   = (ctl_q.state == ST_IDLE);
    assign busy        = (ctl_q.state != ST_IDLE);
    assign exit_valid  = (ctl_q.state == ST_EXIT);
    assign exit_vector = ctl_q.vec;
    assign eoi_wr      = (ctl_q.state == ST_EOI);
    assign eoi_data    = '0;
    assign eval_strobe = (ctl_q.state == ST_EVAL);
    assign desc_on     = ctl_q.on;
    assign desc_pir    = pir_q;
    assign virr        = virr_q;
    assign rvi         = ctl_q.rvi;
endmodule

// File: rtl/pin_notify_chk.sv
module pin_notify_chk #(
    parameter int unsigned VEC_W = 8,
    localparam int unsigned NVEC = 1 << VEC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_ready,
    input logic             busy,
    input logic             exit_valid,
    input logic             eoi_wr,
    input logic [VEC_W-1:0] eoi_data,
    input logic             eval_strobe,
    input logic             post_ready,
    input logic [NVEC-1:0]  desc_pir,
    input logic [NVEC-1:0]  virr,
    input logic [VEC_W-1:0] rvi
);
    a_r1_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_ready);

    a_r2_exit_alone: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (busy && !eoi_wr && !eval_strobe));

    a_r4_eoi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |-> (eoi_data == '0));

    a_r4_eoi_before_merge: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !post_ready);

    a_r5_merge_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !post_ready |=> (desc_pir == '0));

    a_r5_virr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((virr & $past(virr)) == $past(virr)));

    a_r6_rvi_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rvi >= $past(rvi)));

    a_r7_eval_after_merge: assert property (@(posedge clk) disable iff (!rst_n)
        eval_strobe |-> $past(!post_ready));

    a_r8_stall_inside_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        !post_ready |-> busy);
endmodule

bind pin_notify_unit pin_notify_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_ready   (ack_ready),
    .busy        (busy),
    .exit_valid  (exit_valid),
    .eoi_wr      (eoi_wr),
    .eoi_data    (eoi_data),
    .eval_strobe (eval_strobe),
    .post_ready  (post_ready),
    .desc_pir    (desc_pir),
    .virr        (virr),
    .rvi         (rvi)
);

// File: tb/sim_pin_notify_unit.sv
`timescale 1ns/1ps
module sim_pin_notify_unit;
    localparam int VW = 8;
    localparam int NV = 1 << VW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] cfg_notify_vec = 8'hF2;
    logic          ack_valid = 1'b0;
    logic [VW-1:0] ack_vector = '0;
    logic          ack_ready, busy, exit_valid, eoi_wr, eval_strobe, post_ready, desc_on;
    logic [VW-1:0] exit_vector, eoi_data, rvi;
    logic          post_valid = 1'b0;
    logic [VW-1:0] post_bit = '0;
    logic [NV-1:0] desc_pir, virr;

    int n_cmp = 0;
    int n_bad = 0;

    logic [NV-1:0] pir_m, virr_m;
    logic [VW-1:0] rvi_m;
    logic          on_m;

    always #2.5 clk = ~clk;

    pin_notify_unit #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_notify_vec(cfg_notify_vec),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_ready(ack_ready),
        .busy(busy), .exit_valid(exit_valid), .exit_vector(exit_vector),
        .eoi_wr(eoi_wr), .eoi_data(eoi_data), .eval_strobe(eval_strobe),
        .post_valid(post_valid), .post_bit(post_bit), .post_ready(post_ready),
        .desc_on(desc_on), .desc_pir(desc_pir), .virr(virr), .rvi(rvi)
    );

    task automatic check(input bit ok, input string req, input logic [NV-1:0] act,
                         input logic [NV-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int highest(input logic [NV-1:0] v);
        for (int i = NV - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pir_m = '0; virr_m = '0; rvi_m = '0; on_m = 1'b0;
    endtask

    task automatic do_post(input logic [VW-1:0] b);
        @(negedge clk);
        post_valid = 1'b1;
        post_bit   = b;
        @(negedge clk);
        post_valid = 1'b0;
        pir_m[b] = 1'b1;
        on_m     = 1'b1;
    endtask

    task automatic merge_model();
        int h;
        h = highest(pir_m);
        if (h >= 0 && h > int'(rvi_m)) rvi_m = VW'(h);
        virr_m = virr_m | pir_m;
        pir_m  = '0;
        on_m   = 1'b0;
    endtask

    task automatic do_notify();
        @(negedge clk);
        ack_valid  = 1'b1;
        ack_vector = cfg_notify_vec;
        @(negedge clk);
        ack_valid = 1'b0;
        check(busy && !ack_ready, "R1 busy/ready in sequence", {busy, ack_ready}, 2'b10);
        @(negedge clk);
        check(eoi_wr == 1'b1, "R4 eoi strobe", eoi_wr, 1);
        check(eoi_data == '0, "R4 eoi data", eoi_data, 0);
        check(desc_on == 1'b0, "R3 flag cleared", desc_on, 0);
        check(desc_pir == pir_m, "R3 bitmap untouched by clear", desc_pir, pir_m);
        @(negedge clk);
        check(post_ready == 1'b0, "R5 post stalled in merge", post_ready, 0);
        merge_model();
        @(negedge clk);
        check(eval_strobe == 1'b1, "R7 evaluate strobe", eval_strobe, 1);
        check(virr == virr_m, "R5 virr merged", virr, virr_m);
        check(desc_pir == '0, "R5 bitmap cleared", desc_pir, 0);
        check(rvi == rvi_m, "R6 index rule", rvi, rvi_m);
        @(negedge clk);
        check(!busy && ack_ready && !eval_strobe, "R7 sequence ended", {busy, ack_ready, eval_strobe}, 3'b010);
    endtask

    task automatic do_foreign(input logic [VW-1:0] v);
        @(negedge clk);
        ack_valid  = 1'b1;
        ack_vector = v;
        @(negedge clk);
        ack_valid = 1'b0;
        check(exit_valid == 1'b1, "R2 exit raised", exit_valid, 1);
        check(exit_vector == v, "R2 exit vector", exit_vector, v);
        check(!eoi_wr && desc_on == on_m && desc_pir == pir_m, "R2 descriptor untouched",
              desc_pir, pir_m);
        @(negedge clk);
        check(!exit_valid && !busy && !eval_strobe, "R2 single exit cycle", {exit_valid, busy}, 0);
    endtask

    task automatic do_stall(input logic [VW-1:0] b);
        @(negedge clk);
        ack_valid  = 1'b1;
        ack_vector = cfg_notify_vec;
        @(negedge clk);
        ack_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        post_valid = 1'b1;
        post_bit   = b;
        check(post_ready == 1'b0, "R8 stalled during merge", post_ready, 0);
        merge_model();
        @(negedge clk);
        check(post_ready == 1'b1 && eval_strobe, "R8 ready after merge", post_ready, 1);
        @(negedge clk);
        post_valid = 1'b0;
        pir_m[b] = 1'b1;
        on_m     = 1'b1;
        check(desc_pir == pir_m, "R8 stalled post kept", desc_pir, pir_m);
        check(desc_on == 1'b1, "R8 flag set by post", desc_on, 1);
        check(virr == virr_m, "R8 late post not merged", virr, virr_m);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(desc_on == 0 && desc_pir == '0 && virr == '0 && rvi == '0, "R9 reset state",
              desc_pir | virr, 0);
        check(!busy && ack_ready && post_ready, "R9 reset handshakes", {busy, ack_ready, post_ready}, 3'b011);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            do_post(VW'(v));
            check(desc_pir[v] && desc_on, "R8 post sets bit and flag", desc_pir, pir_m);
            do_notify();
            check(rvi == VW'(v), "R6 index from single bit", rvi, VW'(v));
            do_post(VW'(v / 2));
            do_notify();
            check(rvi == VW'(v), "R6 lower bit keeps index", rvi, VW'(v));
            do_notify();
            check(rvi == VW'(v), "R6 empty bitmap keeps index", rvi, VW'(v));
        end

        do_reset();
        do_post(8'd3);
        do_post(8'd77);
        for (int v = 0; v < NV; v++) begin
            if (VW'(v) != cfg_notify_vec) do_foreign(VW'(v));
        end

        do_post(8'd140);
        do_post(8'd9);
        do_notify();
        do_stall(8'd201);
        do_notify();
        check(rvi == 8'd201, "R6 larger bit raises index", rvi, 8'd201);

        cfg_notify_vec = 8'h31;
        do_foreign(8'hF2);
        do_post(8'd250);
        do_notify();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule